// File: doc/BRIEF.md
# Strobe-Modulated Step Counter

This block keeps an 8-bit count that advances on every rising edge of its clock. On most edges it adds two. On every fourth edge a strobe from an internal divide-by-four phase counter is active, and on that edge it subtracts five instead. Over each four-edge period the net change is +1, so the output is a slowly rising sawtooth that wraps around the 8-bit range.

A control module owns the phase counter and sends a small struct of step strobes to a datapath module. The datapath owns the value register and the add/subtract arithmetic. A synchronous reset clears both the value and the phase. After reset the output follows a fixed, repeatable pattern, and this pattern is useful as a known reference waveform next to other clock-derived signals.

Top module: `strobe_step_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the count becomes 0 after that edge, and the phase counter also returns to its start.
- R2: On a rising edge with `rst` low and the strobe inactive, the count increases by exactly 2.
- R3: On a rising edge with `rst` low and the strobe active, the count decreases by exactly 5 and does not also add 2.
- R4: The strobe is active on one edge in every four. The first active edge is the fourth edge after reset is released, and the strobe is never active on two edges in a row.
- R5: After reset is released, the count shows 0, 2, 4, 6, 1, 3, 5, 7, 2, 4, 6, 8, 3, 5, 7, 9 in the first sixteen sampled cycles.
- R6: The arithmetic wraps modulo 256 with no saturation. 254 + 2 gives 0, and 1 − 5 gives 252.
- R7: If reset is asserted on an edge where the strobe would be active, reset wins. The count becomes 0, and the next strobe again falls on the fourth edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of value and phase |
| count | output | 8 | Current counter value |

## Verification
Two pairs of functions can fall on the same edge. The first pair is the subtract strobe and a downward wrap: when the count is below 5 on a strobe edge, the subtraction must cross zero. The second pair is reset and a due strobe.

The first case arises by itself late in a long run with no reset, about a thousand cycles in. The second is provoked by raising reset exactly on the phase where a strobe is due, and also at random phases chosen with `$urandom`.

On every edge the result is judged against a bench model that tracks its own phase. The bench also confirms that both an upward and a downward wrap were actually seen.

// File: rtl/step_counter_pkg.sv
package step_counter_pkg;
  localparam int COUNT_WIDTH = 8;
  localparam int PHASE_COUNT = 4;
  localparam int UP_STEP     = 2;
  localparam int DOWN_STEP   = 5;

  typedef struct packed {
    logic stepUp;
    logic stepDown;
  } stepStrobes_t;
endpackage

// File: rtl/step_phase_ctrl.sv
module step_phase_ctrl
  import step_counter_pkg::*;
#(
  parameter int PHASES = PHASE_COUNT
) (
  input  logic         clk,
  input  logic         rst,
  output stepStrobes_t strobes
);
  localparam int PHASE_W = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(PHASES - 1);

  logic [PHASE_W-1:0] phase;
  logic               terminal;

  assign terminal = (phase == LAST_PHASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (terminal) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  always_comb begin
    strobes.stepDown = !rst && terminal;
    strobes.stepUp   = !rst && !terminal;
  end

  // R4: never both strobes at once
  assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.stepUp, strobes.stepDown}));

  // R4: a down strobe is never followed directly by another
  assert_no_back_to_back_R4: assert property (@(posedge clk) disable iff (rst)
    strobes.stepDown |=> !strobes.stepDown);

  // R1: reset returns the phase to its start, so the next edge is not a strobe
  assert_phase_restart_R1: assert property (@(posedge clk)
    rst |=> (phase == '0));
endmodule

// File: rtl/step_value_path.sv
module step_value_path
  import step_counter_pkg::*;
#(
  parameter int WIDTH    = COUNT_WIDTH,
  parameter int UP_BY    = UP_STEP,
  parameter int DOWN_BY  = DOWN_STEP
) (
  input  logic             clk,
  input  logic             rst,
  input  stepStrobes_t     strobes,
  output logic [WIDTH-1:0] value
);
  localparam logic [WIDTH-1:0] UP_W   = WIDTH'(UP_BY);
  localparam logic [WIDTH-1:0] DOWN_W = WIDTH'(DOWN_BY);

  logic [WIDTH-1:0] nextValue;

  always_comb begin
    nextValue = value;
    if (strobes.stepDown) begin
      nextValue = value - DOWN_W;
    end else if (strobes.stepUp) begin
      nextValue = value + UP_W;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
    end else begin
      value <= nextValue;
    end
  end

  // R1: reset clears the value
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (value == '0));

  // R2 and R6: a plain edge adds the up step, wrapping modulo 2^WIDTH
  assert_up_step_R2: assert property (@(posedge clk) disable iff (rst)
    strobes.stepUp |=> (rst || value == WIDTH'($past(value) + UP_W)));

  // R3 and R6: a strobe edge subtracts the down step, wrapping modulo 2^WIDTH
  assert_down_step_R3: assert property (@(posedge clk) disable iff (rst)
    strobes.stepDown |=> (rst || value == WIDTH'($past(value) - DOWN_W)));
endmodule

// File: rtl/strobe_step_counter.sv
module strobe_step_counter
  import step_counter_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  output logic [COUNT_WIDTH-1:0] count
);
  stepStrobes_t strobes;

  step_phase_ctrl #(
    .PHASES (PHASE_COUNT)
  ) ctrl (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes)
  );

  step_value_path #(
    .WIDTH   (COUNT_WIDTH),
    .UP_BY   (UP_STEP),
    .DOWN_BY (DOWN_STEP)
  ) path (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .value   (count)
  );
endmodule

// File: tb/strobe_step_counter_test.sv
module strobe_step_counter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] count;

  int checks = 0;
  int fails  = 0;
  int modelVal = 0;
  int modelPhase = 0;
  bit wrapUpSeen = 0;
  bit wrapDownSeen = 0;
  string lastTag = "R2";

  strobe_step_counter uut (.clk(clk), .rst(rst), .count(count));

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected result of one edge, from the requirements
  function automatic int stepModel(input int v, input int ph, input bit r);
    if (r) return 0;
    if (ph == 3) return (v + 256 - 5) % 256;
    return (v + 2) % 256;
  endfunction

  function automatic int phaseModel(input int ph, input bit r);
    if (r) return 0;
    return (ph + 1) % 4;
  endfunction

  // One clock: model advances at the edge, check at the falling edge
  task automatic cycle();
    @(posedge clk);
    if (rst) lastTag = "R1";
    else if (modelPhase == 3) begin
      lastTag = "R3";
      if (modelVal < 5) begin wrapDownSeen = 1; lastTag = "R6"; end
    end else begin
      lastTag = "R2";
      if (modelVal > 253) begin wrapUpSeen = 1; lastTag = "R6"; end
    end
    modelVal   = stepModel(modelVal, modelPhase, rst);
    modelPhase = phaseModel(modelPhase, rst);
    @(negedge clk);
    check(lastTag, count, modelVal);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seq[16] = '{0, 2, 4, 6, 1, 3, 5, 7, 2, 4, 6, 8, 3, 5, 7, 9};
    void'($urandom(32'd7541));

    // R1: reset state
    repeat (3) cycle();
    check("R1", count, 0);

    // R5: fixed pattern after release (first sample is the reset value)
    rst = 1'b0;
    check("R5", count, seq[0]);
    for (int i = 1; i < 16; i++) begin
      cycle();
      check("R5", count, seq[i]);
    end

    // R2, R3, R6: long run through both wrap directions
    for (int i = 0; i < 1100; i++) cycle();
    check("R6", int'(wrapUpSeen), 1);
    check("R6", int'(wrapDownSeen), 1);

    // R7: reset on the edge where a strobe is due
    while (modelPhase != 3) cycle();
    rst = 1'b1;
    cycle();
    check("R7", count, 0);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      cycle();
      check("R7", count, seq[i + 1]);
    end

    // R4, R7: random reset points and random run lengths
    for (int seg = 0; seg < 25; seg++) begin
      int runLen = $urandom_range(1, 40);
      int rstLen = $urandom_range(1, 3);
      for (int i = 0; i < runLen; i++) cycle();
      rst = 1'b1;
      for (int i = 0; i < rstLen; i++) cycle();
      check("R7", count, 0);
      rst = 1'b0;
      for (int i = 0; i < 4; i++) cycle();
      check("R4", count, 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule